// File: doc/BRIEF.md
# Instruction Cache Set Parity Scanner

This block inspects one set of a four-way instruction cache for parity damage. A scan opens with a `start` strobe that captures the set index and a data-check enable. The block then walks the ways in order 0 to 3. For each way it takes one tag word. When data checking is on, it then takes four data beats. Each word arrives on a single `word_valid` strobe. The block is ready for a word in every cycle of a scan, so every strobe inside a scan is consumed in the cycle it is presented. The `rd_addr` output names the array location the next word must come from.

Each tag word is judged on three points:
- the duplicated valid bit;
- two tag-slice parities, checked only for valid lines.

Each data beat is judged on two points:
- the parity of its eight predecode bits;
- eight even byte parities, four for each of its two instructions.

Failures collect in two sticky flags, one for tag faults and one for data faults. A one-cycle `done` pulse follows the last word. Every tag word also yields a reconstructed virtual address, which is presented for one cycle on `va_valid`.

The controller has four states:
- `ST_IDLE` waits for `start`, then goes to `ST_TAG`.
- `ST_TAG` takes a tag word. With data checking on it goes to `ST_DATA`. Otherwise it moves to the next way's `ST_TAG`, or to `ST_DONE` after way 3.
- `ST_DATA` takes beats 0 to 3. After beat 3 it goes to the next way's `ST_TAG`, or to `ST_DONE` after way 3.
- `ST_DONE` lasts one cycle, asserts `done`, and returns to `ST_IDLE`.

Top module: `icache_parity_chk`

## Requirements
- R1: After reset the block is in `ST_IDLE`, and `done`, `tag_err`, `data_err` and `va_valid` are all 0.
- R2: `start` in `ST_IDLE` captures `index` and `data_en` and clears both error flags. During a scan, `rd_addr` = {way[1:0], index[12:5], beat[1:0], 3'b000}, with the beat offset in bits 4:3 and the beat forced to 0 while a tag word is expected. Ways are visited 0 to 3, each as a tag word followed by its beats.
- R3: The valid bit is `tag_hi[29]` and its copy is `tag_hi[27]`. If the two differ, `tag_err` is set whether or not the line is valid.
- R4: For a valid line, `tag_lo[10]` must equal the XOR of `tag_lo[23:12]` and `tag_lo[9:0]`. A mismatch sets `tag_err`. For an invalid line this check is skipped.
- R5: For a valid line, `tag_lo[11]` must equal the XOR of `tag_lo[63:24]`. A mismatch sets `tag_err`. For an invalid line this check is skipped.
- R6: In a data beat, `side[16]` must equal the XOR of the predecode bits `side[15:8]`. A mismatch sets `data_err`.
- R7: For i = 0 to 3, `side[4+i]` must equal the XOR of `inst_a[8i+7:8i]` and `side[i]` must equal the XOR of `inst_b[8i+7:8i]`. Any mismatch sets `data_err`.
- R8: With `data_en` low at `start`, a scan takes exactly four tag words and then ends. The data inputs are ignored and `data_err` stays 0.
- R9: The error flags are sticky for the whole scan and hold after it until the next `start`. `done` is high for exactly the one cycle after the edge that accepts the final word.
- R10: In the cycle after each tag word is accepted, `va_valid` is 1 and `va` = {tag_lo[63:62], fill, tag_lo[43:13], index[12:0]}. Here `fill` is 18 ones when `tag_lo[31]` is 1 and `tag_lo[63:62]` is 3, and 18 zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan; honoured only in idle |
| index | input | 13 | Set index, bits 12:5 significant |
| data_en | input | 1 | Enable data-beat checking for this scan |
| word_valid | input | 1 | A tag word or data beat is present |
| tag_hi | input | 32 | Tag high word (valid bit and its copy) |
| tag_lo | input | 64 | Tag low word (address tag and two parities) |
| inst_a | input | 32 | First instruction of a data beat |
| inst_b | input | 32 | Second instruction of a data beat |
| side | input | 17 | Predecode bits, predecode parity and byte parities |
| rd_addr | output | 15 | Array location of the expected word |
| done | output | 1 | One-cycle end-of-scan pulse |
| tag_err | output | 1 | Sticky tag-parity fault flag |
| data_err | output | 1 | Sticky data-parity fault flag |
| va_valid | output | 1 | `va` holds a fresh address |
| va | output | 64 | Reconstructed virtual address |

## Verification
The collision that matters is a data fault on beat 3 of way 3. The cycle that records that fault is the same cycle in which the controller commits to `ST_DONE`. The tests therefore put a predecode fault, and separately an instruction-byte fault, on exactly that final beat. They then require `data_err` to be high in the very cycle `done` pulses, not one cycle later. A second case puts a tag fault on way 3 in a tag-only scan, so that the tag flag and the end pulse coincide in the same way.

// File: rtl/icp_pkg.sv
package icp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TAG,
        ST_DATA,
        ST_DONE
    } scan_st_e;

    localparam int TAGH_W = 32;
    localparam int TAGL_W = 64;
    localparam int INST_W = 32;
    localparam int SIDE_W = 17;
endpackage

// File: rtl/icp_tag_eval.sv
module icp_tag_eval
    import icp_pkg::*;
#(
    parameter int IDX_W = 13
) (
    input  logic [TAGH_W-1:0] tag_hi,
    input  logic [TAGL_W-1:0] tag_lo,
    input  logic [IDX_W-1:0]  index,
    output logic              bad,
    output logic [TAGL_W-1:0] va
);
    localparam int FILL_W = 18;

    logic line_ok;
    logic lo_par;
    logic hi_par;
    logic fill_en;

    always_comb begin
        line_ok = tag_hi[29];
        lo_par  = ^{tag_lo[23:12], tag_lo[9:0]};
        hi_par  = ^tag_lo[63:24];
        bad     = (tag_hi[29] ^ tag_hi[27])
                | (line_ok & (tag_lo[10] ^ lo_par))
                | (line_ok & (tag_lo[11] ^ hi_par));
        fill_en = tag_lo[31] & (tag_lo[63:62] == 2'b11);
        va      = {tag_lo[63:62],
                   fill_en ? {FILL_W{1'b1}} : {FILL_W{1'b0}},
                   tag_lo[43:IDX_W],
                   index};
    end
endmodule

// File: rtl/icp_beat_eval.sv
module icp_beat_eval
    import icp_pkg::*;
(
    input  logic [INST_W-1:0] inst_a,
    input  logic [INST_W-1:0] inst_b,
    input  logic [SIDE_W-1:0] side,
    output logic              bad
);
    localparam int NBYTE = INST_W / 8;

    logic [NBYTE-1:0] a_miss;
    logic [NBYTE-1:0] b_miss;
    logic             pd_miss;

    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        assign a_miss[i] = side[NBYTE+i] ^ (^inst_a[8*i+7:8*i]);
        assign b_miss[i] = side[i] ^ (^inst_b[8*i+7:8*i]);
    end

    assign pd_miss = side[16] ^ (^side[15:8]);
    assign bad     = pd_miss | (|a_miss) | (|b_miss);
endmodule

// File: rtl/icache_parity_chk.sv
module icache_parity_chk
    import icp_pkg::*;
#(
    parameter int IDX_W = 13,
    parameter int WAYS  = 4,
    parameter int BEATS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [12:0]       index,
    input  logic              data_en,
    input  logic              word_valid,
    input  logic [31:0]       tag_hi,
    input  logic [63:0]       tag_lo,
    input  logic [31:0]       inst_a,
    input  logic [31:0]       inst_b,
    input  logic [16:0]       side,
    output logic [14:0]       rd_addr,
    output logic              done,
    output logic              tag_err,
    output logic              data_err,
    output logic              va_valid,
    output logic [63:0]       va
);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int BEAT_W  = $clog2(BEATS);
    localparam int OFF_LSB = 3;
    localparam int SET_LSB = OFF_LSB + BEAT_W;

    scan_st_e          state, nxt;
    logic [WAY_W-1:0]  way_q;
    logic [BEAT_W-1:0] beat_q;
    logic [IDX_W-1:0]  idx_q;
    logic              den_q;
    logic              last_way, last_beat;
    logic              tag_bad, beat_bad;
    logic [63:0]       va_n;

    icp_tag_eval #(.IDX_W(IDX_W)) u_tag (
        .tag_hi (tag_hi),
        .tag_lo (tag_lo),
        .index  (idx_q),
        .bad    (tag_bad),
        .va     (va_n)
    );

    icp_beat_eval u_beat (
        .inst_a (inst_a),
        .inst_b (inst_b),
        .side   (side),
        .bad    (beat_bad)
    );

    assign last_way  = (way_q == WAY_W'(WAYS - 1));
    assign last_beat = (beat_q == BEAT_W'(BEATS - 1));
    assign rd_addr   = {way_q, idx_q[IDX_W-1:SET_LSB], beat_q, {OFF_LSB{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_TAG;
            ST_TAG:  if (word_valid) begin
                         if (den_q)         nxt = ST_DATA;
                         else if (last_way) nxt = ST_DONE;
                     end
            ST_DATA: if (word_valid && last_beat) nxt = last_way ? ST_DONE : ST_TAG;
            ST_DONE: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            way_q    <= '0;
            beat_q   <= '0;
            idx_q    <= '0;
            den_q    <= 1'b0;
            tag_err  <= 1'b0;
            data_err <= 1'b0;
            done     <= 1'b0;
            va_valid <= 1'b0;
            va       <= '0;
        end else begin
            done     <= (nxt == ST_DONE);
            va_valid <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    idx_q    <= index;
                    den_q    <= data_en;
                    way_q    <= '0;
                    beat_q   <= '0;
                    tag_err  <= 1'b0;
                    data_err <= 1'b0;
                end
                ST_TAG: if (word_valid) begin
                    tag_err  <= tag_err | tag_bad;
                    va       <= va_n;
                    va_valid <= 1'b1;
                    beat_q   <= '0;
                    if (!den_q) way_q <= way_q + 1'b1;
                end
                ST_DATA: if (word_valid) begin
                    data_err <= data_err | beat_bad;
                    if (last_beat) begin
                        beat_q <= '0;
                        way_q  <= way_q + 1'b1;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (!tag_err && !data_err));

    // R9
    tag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_err && !(state == ST_IDLE && start)) |=> tag_err);

    // R9
    data_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_err && !(state == ST_IDLE && start)) |=> data_err);

    // R8
    tag_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> den_q);

    // R2
    tag_beat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAG) |-> (rd_addr[4:3] == 2'b00));
endmodule

// File: tb/sim_icache_parity_chk.sv
module sim_icache_parity_chk;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] index = '0;
    logic        data_en = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] tag_hi = '0;
    logic [63:0] tag_lo = '0;
    logic [31:0] inst_a = '0;
    logic [31:0] inst_b = '0;
    logic [16:0] side = '0;
    logic [14:0] rd_addr;
    logic        done, tag_err, data_err, va_valid;
    logic [63:0] va;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icache_parity_chk u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .index(index), .data_en(data_en),
        .word_valid(word_valid), .tag_hi(tag_hi), .tag_lo(tag_lo),
        .inst_a(inst_a), .inst_b(inst_b), .side(side), .rd_addr(rd_addr),
        .done(done), .tag_err(tag_err), .data_err(data_err),
        .va_valid(va_valid), .va(va)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_tag_lo(input int w);
        logic [63:0] t;
        t = 64'h1B57_9D3F_2468_ACE0 ^ (64'h0F0F_3C3C_5A5A_9669 << (w * 5));
        t[12:0] = '0;
        if (w == 2) begin t[63:62] = 2'b11; t[31] = 1'b1; end
        if (w == 1) begin t[63:62] = 2'b11; t[31] = 1'b0; end
        if (w == 3) begin t[63:62] = 2'b10; t[31] = 1'b1; end
        t[11] = ^t[63:24];
        t[10] = 1'b0;
        for (int k = 0; k < 24; k++)
            if (k != 10 && k != 11) t[10] = t[10] ^ t[k];
        return t;
    endfunction

    function automatic logic [16:0] mk_side(input logic [31:0] a, input logic [31:0] b, input logic [7:0] pd);
        logic [16:0] s;
        s[16]   = ^pd;
        s[15:8] = pd;
        for (int i = 0; i < 4; i++) begin
            s[4+i] = ^a[8*i +: 8];
            s[i]   = ^b[8*i +: 8];
        end
        return s;
    endfunction

    function automatic logic [63:0] exp_va(input logic [63:0] t, input logic [12:0] idx);
        logic fl;
        fl = t[31] && (t[63:62] == 2'b11);
        return {t[63:62], fl ? 18'h3FFFF : 18'h0, t[43:13], idx};
    endfunction

    // fault kinds: 0 none, 1 valid copy flip, 2 tag_lo[10] flip, 3 tag_lo[11] flip,
    // 4 predecode parity flip, 5 inst A byte parity flip, 6 inst B byte parity flip,
    // 7 invalid line with both tag parities wrong (no error expected)
    task automatic run_scan(input string name, input bit den, input int kind,
                            input int fway, input int fbeat, input logic [12:0] idx);
        bit exp_t, exp_d;
        exp_t = (kind >= 1 && kind <= 3);
        exp_d = den && (kind >= 4 && kind <= 6);
        @(negedge clk);
        start = 1'b1; index = idx; data_en = den;
        @(negedge clk);
        start = 1'b0; data_en = ~den;
        chk(!tag_err && !data_err, {"R2 flags cleared ", name}, {62'b0, tag_err, data_err}, 64'h0);
        for (int w = 0; w < 4; w++) begin
            logic [31:0] th;
            logic [63:0] tl;
            th = 32'h2800_1234;
            tl = mk_tag_lo(w);
            if (w == fway) begin
                if (kind == 1) th[27] = ~th[27];
                if (kind == 2) tl[10] = ~tl[10];
                if (kind == 3) tl[11] = ~tl[11];
                if (kind == 7) begin th[29] = 1'b0; th[27] = 1'b0; tl[10] = ~tl[10]; tl[11] = ~tl[11]; end
            end
            chk(rd_addr == {w[1:0], idx[12:5], 2'b00, 3'b000}, {"R2 tag rd_addr ", name},
                {49'b0, rd_addr}, {49'b0, w[1:0], idx[12:5], 5'b0});
            word_valid = 1'b1; tag_hi = th; tag_lo = tl;
            inst_a = 32'hFFFF_FFFE; inst_b = 32'h0; side = 17'h1FFFF;
            @(negedge clk);
            chk(va_valid && va == exp_va(tl, idx), {"R10 va ", name}, va, exp_va(tl, idx));
            if (den) begin
                for (int b = 0; b < 4; b++) begin
                    logic [31:0] a, bb;
                    logic [7:0]  pd;
                    logic [16:0] s;
                    a  = 32'h9E37_79B9 + w * 32'h0101_0307 + b * 32'h1357_9BDF;
                    bb = ~a ^ {a[15:0], a[31:16]};
                    pd = 8'h5A ^ 8'(b * 17 + w);
                    s  = mk_side(a, bb, pd);
                    if (w == fway && b == fbeat) begin
                        if (kind == 4) s[16] = ~s[16];
                        if (kind == 5) s[7]  = ~s[7];
                        if (kind == 6) s[1]  = ~s[1];
                    end
                    chk(rd_addr == {w[1:0], idx[12:5], b[1:0], 3'b000}, {"R2 beat rd_addr ", name},
                        {49'b0, rd_addr}, {49'b0, w[1:0], idx[12:5], b[1:0], 3'b0});
                    inst_a = a; inst_b = bb; side = s;
                    @(negedge clk);
                end
            end
        end
        word_valid = 1'b0;
        chk(done == 1'b1, {"R9 done after last word ", name}, {63'b0, done}, 64'h1);
        chk(tag_err == exp_t, {"R3 R4 R5 tag flag ", name}, {63'b0, tag_err}, {63'b0, exp_t});
        chk(data_err == exp_d, {"R6 R7 R8 data flag ", name}, {63'b0, data_err}, {63'b0, exp_d});
        @(negedge clk);
        chk(done == 1'b0, {"R9 done single cycle ", name}, {63'b0, done}, 64'h0);
        chk(tag_err == exp_t && data_err == exp_d, {"R9 flags held ", name},
            {62'b0, tag_err, data_err}, {62'b0, exp_t, exp_d});
    endtask

    task automatic t_reset;
        chk(!done && !tag_err && !data_err && !va_valid, "R1 reset outputs",
            {60'b0, done, tag_err, data_err, va_valid}, 64'h0);
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        chk(!va_valid && !done, "R1 idle ignores words", {62'b0, va_valid, done}, 64'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_scan("clean full",        1'b1, 0, 0, 0, 13'h1FE0);
        run_scan("valid copy R3",     1'b1, 1, 1, 0, 13'h0AC0);
        run_scan("invalid copy R3",   1'b0, 1, 2, 0, 13'h0140);
        run_scan("tag low R4",        1'b1, 2, 0, 0, 13'h1540);
        run_scan("tag high R5",       1'b0, 3, 3, 0, 13'h0FE0);
        run_scan("invalid skip R4R5", 1'b1, 7, 2, 0, 13'h0860);
        run_scan("predecode R6 last", 1'b1, 4, 3, 3, 13'h1220);
        run_scan("inst A R7",         1'b1, 5, 1, 2, 13'h0020);
        run_scan("inst B R7 last",    1'b1, 6, 3, 3, 13'h1FE0);
        run_scan("tag only R8",       1'b0, 0, 0, 0, 13'h0AA0);
        run_scan("clean after err",   1'b1, 0, 0, 0, 13'h0000);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule